// File: doc/BRIEF.md
# Least-Seen Cluster Test Vector Selector

This block sits in front of the inputs of a combinational circuit under test (CUT). It tests that circuit concurrently, using its normal inputs as test vectors, and fills the gaps in those inputs during idle time. The full test set is split at design time into a fixed number of clusters, and each cluster's vectors are held in a small read-only memory. While the system runs, every accepted functional input is matched against all stored vectors. The counter of the cluster that contains it is incremented and saturates at its ceiling.

A minimum search over the counters runs continuously. When the power manager raises its low-power request, the block latches the index of the least-seen cluster. It then replaces the functional input of the CUT with that cluster's stored vectors, one per cycle. A session stops in one of three ways: the subset is exhausted, a cycle limit is reached, or the low-power request drops. A session that runs to completion raises that cluster's counter above the current maximum, so the next idle period favours another cluster.

Top module: `abist_selector`

## Requirements
- R1: While `rst` is high, `cut_in`, `test_active`, `sel_cluster` and `cluster_hit` are all zero on the next clock edge, and all hit counters clear to zero.
- R2: Stored vector j of cluster c has the value (37*(c*VPC+j)+5) mod 2^VEC_W. An input is accepted when `in_valid` is 1 and no session is running. In the cycle after an accepted input, `cluster_hit` is one-hot at bit c of the cluster holding that value. `cluster_hit` is all zero when no cluster holds the value or no input was accepted.
- R3: An accepted input increments the counter of its cluster by one. A counter saturates at 2^CNT_W-1. An unmatched input, an input with `in_valid` low, or an input presented during a session leaves every counter unchanged.
- R4: A session starts on the first clock edge that samples `lp_mode` high after it was low while no session is active. At that edge the block latches the index of the smallest counter into `sel_cluster`, with ties going to the lowest index. `sel_cluster` holds that value until the next session starts.
- R5: Outside a session, `cut_in` equals `func_in` delayed by one clock.
- R6: On each edge after the start edge that samples `lp_mode` high, the block emits the selected cluster's next vector in order j=0,1,... After such an edge, `test_active` is 1 and `cut_in` carries that vector.
- R7: A session emits at most WINDOW_CYCLES vectors. When this limit ends a session early, the counter of the selected cluster is left unchanged. No further vectors are emitted until `lp_mode` falls and rises again.
- R8: When the last vector of a subset is emitted, the selected cluster's counter becomes the largest counter value plus one, clipped at saturation. No further vectors are emitted until `lp_mode` falls and rises again.
- R9: An edge that samples `lp_mode` low during a session emits nothing. After that edge `test_active` is 0 and `cut_in` returns to the functional path, and the counter is left unchanged. The next session starts again at j=0 of the cluster chosen at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_in | input | VEC_W | Functional input vector bound for the CUT |
| in_valid | input | 1 | `func_in` carries a new input this cycle |
| lp_mode | input | 1 | Low-power or idle request from the power manager |
| cut_in | output | VEC_W | Vector driven into the CUT |
| test_active | output | 1 | `cut_in` carries a stored test vector |
| sel_cluster | output | $clog2(NUM_CL) | Cluster latched at the latest session start |
| cluster_hit | output | NUM_CL | One-hot cluster match of the last accepted input |

## Verification
The bench feeds uneven hit mixes: a single least-seen cluster, two clusters tied at the minimum, unmatched values, and matching values with `in_valid` low. These separate a correct argmin, the lowest-index tie rule and ignored inputs from counting errors. A full session followed by a second one shows the post-completion raise moving the choice. A session cut short by `lp_mode` shows the abort and the restart from the first vector. A long burst of hits drives the counters to their ceiling, where saturation picks a different cluster than wrap-around would. A second instance with a two-cycle limit shows the window cut-off and that the counter is not raised after it.

// File: rtl/abist_pkg.sv
package abist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } sess_state_t;

  localparam int unsigned CODE_MULT = 37;
  localparam int unsigned CODE_OFFS = 5;

  // Stored vector for flat index n = cluster*VPC + position
  function automatic int unsigned vec_code(int unsigned n);
    return CODE_MULT * n + CODE_OFFS;
  endfunction

endpackage

// File: rtl/abist_cluster_match.sv
module abist_cluster_match #(
  parameter int NUM_CL = 4,
  parameter int VEC_W  = 8,
  parameter int VPC    = 4
) (
  input  logic [VEC_W-1:0]  vec_i,
  output logic [NUM_CL-1:0] hit_o
);

  for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
    logic [VPC-1:0] eq;
    for (genvar j = 0; j < VPC; j++) begin : g_v
      localparam logic [VEC_W-1:0] CODE = VEC_W'(abist_pkg::vec_code(c * VPC + j));
      assign eq[j] = (vec_i == CODE);
    end
    assign hit_o[c] = |eq;
  end

endmodule

// File: rtl/abist_hit_counters.sv
module abist_hit_counters #(
  parameter int NUM_CL = 4,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CL-1:0]              inc_i,
  input  logic                           bump_en_i,
  input  logic [IDX_W-1:0]               bump_idx_i,
  input  logic [CNT_W-1:0]               bump_val_i,
  output logic [NUM_CL-1:0][CNT_W-1:0]   cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_CL];

  for (genvar c = 0; c < NUM_CL; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[c] <= '0;
      end else if (bump_en_i && (bump_idx_i == IDX_W'(c))) begin
        cnt_q[c] <= bump_val_i;
      end else if (inc_i[c] && (cnt_q[c] != CNT_MAX)) begin
        cnt_q[c] <= cnt_q[c] + 1'b1;
      end
    end
    assign cnt_o[c] = cnt_q[c];
  end

endmodule

// File: rtl/abist_min_select.sv
module abist_min_select #(
  parameter int NUM_CL = 4,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CL-1:0][CNT_W-1:0] cnt_i,
  output logic [IDX_W-1:0]             min_idx_o,
  output logic [CNT_W-1:0]             max_val_o
);

  logic [CNT_W-1:0] min_v;

  // Strict compare keeps the lowest index on ties
  always_comb begin
    min_idx_o = '0;
    min_v     = cnt_i[0];
    max_val_o = cnt_i[0];
    for (int c = 1; c < NUM_CL; c++) begin
      if (cnt_i[c] < min_v) begin
        min_v     = cnt_i[c];
        min_idx_o = IDX_W'(c);
      end
      if (cnt_i[c] > max_val_o) begin
        max_val_o = cnt_i[c];
      end
    end
  end

endmodule

// File: rtl/abist_vec_rom.sv
module abist_vec_rom #(
  parameter int VEC_W  = 8,
  parameter int VPC    = 4,
  parameter int ADDR_W = 2,
  parameter int CL_ID  = 0
) (
  input  logic              clk,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [VEC_W-1:0]  data_o
);

  logic [VEC_W-1:0] mem [VPC];

  initial begin
    for (int j = 0; j < VPC; j++) begin
      mem[j] = VEC_W'(abist_pkg::vec_code(CL_ID * VPC + j));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) begin
      data_o <= mem[addr_i];
    end
  end

endmodule

// File: rtl/abist_selector.sv
module abist_selector #(
  parameter int NUM_CL        = 4,
  parameter int VEC_W         = 8,
  parameter int VPC           = 4,
  parameter int CNT_W         = 16,
  parameter int WINDOW_CYCLES = 1000000000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [VEC_W-1:0]          func_in,
  input  logic                      in_valid,
  input  logic                      lp_mode,
  output logic [VEC_W-1:0]          cut_in,
  output logic                      test_active,
  output logic [$clog2(NUM_CL)-1:0] sel_cluster,
  output logic [NUM_CL-1:0]         cluster_hit
);

  import abist_pkg::*;

  localparam int IDX_W    = $clog2(NUM_CL);
  localparam int ADDR_W   = $clog2(VPC);
  localparam int STEP_LIM = (WINDOW_CYCLES > VPC) ? WINDOW_CYCLES : VPC;
  localparam int STEP_W   = $clog2(STEP_LIM) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  sess_state_t              state_q;
  logic                     lp_d;
  logic [STEP_W-1:0]        step_q;
  logic [IDX_W-1:0]         sel_q;
  logic                     ta_q;
  logic [VEC_W-1:0]         func_q;
  logic [NUM_CL-1:0]        hit_q;

  logic [NUM_CL-1:0]        hit_comb;
  logic [NUM_CL-1:0]        inc;
  logic [NUM_CL-1:0][CNT_W-1:0] counts;
  logic [IDX_W-1:0]         min_idx;
  logic [CNT_W-1:0]         max_val;
  logic [CNT_W-1:0]         bump_val;
  logic                     emit, accept, last_vec, win_end, bump_en;
  logic [VEC_W-1:0]         rom_q [NUM_CL];

  assign emit     = (state_q == ST_RUN) && lp_mode;
  assign accept   = in_valid && (state_q != ST_RUN);
  assign last_vec = (step_q == STEP_W'(VPC - 1));
  assign win_end  = (step_q == STEP_W'(WINDOW_CYCLES - 1));
  assign bump_en  = emit && last_vec;
  assign bump_val = (max_val == CNT_MAX) ? max_val : max_val + 1'b1;
  assign inc      = hit_comb & {NUM_CL{accept}};

  abist_cluster_match #(
    .NUM_CL(NUM_CL), .VEC_W(VEC_W), .VPC(VPC)
  ) u_match (
    .vec_i (func_in),
    .hit_o (hit_comb)
  );

  abist_hit_counters #(
    .NUM_CL(NUM_CL), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .inc_i      (inc),
    .bump_en_i  (bump_en),
    .bump_idx_i (sel_q),
    .bump_val_i (bump_val),
    .cnt_o      (counts)
  );

  abist_min_select #(
    .NUM_CL(NUM_CL), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_min (
    .cnt_i     (counts),
    .min_idx_o (min_idx),
    .max_val_o (max_val)
  );

  for (genvar c = 0; c < NUM_CL; c++) begin : g_rom
    abist_vec_rom #(
      .VEC_W(VEC_W), .VPC(VPC), .ADDR_W(ADDR_W), .CL_ID(c)
    ) u_rom (
      .clk     (clk),
      .rd_en_i (emit),
      .addr_i  (step_q[ADDR_W-1:0]),
      .data_o  (rom_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lp_d    <= 1'b0;
      step_q  <= '0;
      sel_q   <= '0;
      ta_q    <= 1'b0;
      func_q  <= '0;
      hit_q   <= '0;
    end else begin
      lp_d   <= lp_mode;
      ta_q   <= emit;
      func_q <= func_in;
      hit_q  <= inc;
      case (state_q)
        ST_IDLE: begin
          if (lp_mode && !lp_d) begin
            sel_q   <= min_idx;
            step_q  <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (!lp_mode) begin
            state_q <= ST_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
            if (last_vec || win_end) state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!lp_mode) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cut_in      = ta_q ? rom_q[sel_q] : func_q;
  assign test_active = ta_q;
  assign sel_cluster = sel_q;
  assign cluster_hit = hit_q;

endmodule

// File: rtl/abist_selector_chk.sv
module abist_selector_chk #(
  parameter int NUM_CL = 4,
  parameter int VEC_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [VEC_W-1:0]          func_in,
  input logic                      lp_mode,
  input logic [VEC_W-1:0]          cut_in,
  input logic                      test_active,
  input logic [$clog2(NUM_CL)-1:0] sel_cluster,
  input logic [NUM_CL-1:0]         cluster_hit
);

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cluster_hit)); // R2

  AST_NO_HIT_IN_TEST: assert property (@(posedge clk) disable iff (rst)
    test_active |-> (cluster_hit == '0)); // R3

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (test_active && $past(test_active)) |-> $stable(sel_cluster)); // R4

  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !test_active) |-> (cut_in == $past(func_in))); // R5

  AST_EMIT_NEEDS_LP: assert property (@(posedge clk) disable iff (rst)
    test_active |-> $past(lp_mode)); // R6

  AST_START_NO_EMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(lp_mode) |=> !test_active); // R6

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !lp_mode |=> !test_active); // R9

endmodule

bind abist_selector abist_selector_chk #(
  .NUM_CL(NUM_CL), .VEC_W(VEC_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .func_in     (func_in),
  .lp_mode     (lp_mode),
  .cut_in      (cut_in),
  .test_active (test_active),
  .sel_cluster (sel_cluster),
  .cluster_hit (cluster_hit)
);

// File: tb/abist_selector_tb_top.sv
`timescale 1ns/1ps
module abist_selector_tb_top;

  localparam int NUM_CL = 4;
  localparam int VEC_W  = 8;
  localparam int VPC    = 4;
  localparam int CNT_W  = 6;
  localparam int WIN_I  = 1000;
  localparam int WIN_W  = 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VEC_W-1:0] func_in = '0;
  logic in_valid = 1'b0;
  logic lp_mode  = 1'b0;

  logic [VEC_W-1:0] cut_i, cut_w;
  logic ta_i, ta_w;
  logic [1:0] sel_i, sel_w;
  logic [NUM_CL-1:0] hit_i, hit_w;

  always #2 clk = ~clk;

  abist_selector #(.NUM_CL(NUM_CL), .VEC_W(VEC_W), .VPC(VPC), .CNT_W(CNT_W),
                   .WINDOW_CYCLES(WIN_I)) dut_i (
    .clk(clk), .rst(rst), .func_in(func_in), .in_valid(in_valid), .lp_mode(lp_mode),
    .cut_in(cut_i), .test_active(ta_i), .sel_cluster(sel_i), .cluster_hit(hit_i));

  abist_selector #(.NUM_CL(NUM_CL), .VEC_W(VEC_W), .VPC(VPC), .CNT_W(CNT_W),
                   .WINDOW_CYCLES(WIN_W)) dut_w (
    .clk(clk), .rst(rst), .func_in(func_in), .in_valid(in_valid), .lp_mode(lp_mode),
    .cut_in(cut_w), .test_active(ta_w), .sel_cluster(sel_w), .cluster_hit(hit_w));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int vecval(input int c, input int j);
    return (37 * (c * VPC + j) + 5) % 256;
  endfunction

  // Behavioural reference for dut_i
  int m_cnt [NUM_CL];
  int m_state, m_idx, m_sel, m_lpd, m_ta, m_rom, m_func, m_hit;
  bit started = 0;

  always @(posedge clk) begin : model
    int mi, mx, hc;
    bit emit, lp;
    lp = lp_mode;
    if (rst) begin
      foreach (m_cnt[c]) m_cnt[c] = 0;
      m_state = 0; m_idx = 0; m_sel = 0; m_lpd = 0;
      m_ta = 0; m_rom = 0; m_func = 0; m_hit = 0;
      started = 1;
    end else begin
      emit = (m_state == 1) && lp;
      mi = 0; mx = m_cnt[0];
      for (int c = 1; c < NUM_CL; c++) begin
        if (m_cnt[c] < m_cnt[mi]) mi = c;
        if (m_cnt[c] > mx) mx = m_cnt[c];
      end
      hc = -1;
      if (in_valid && m_state != 1)
        for (int c = 0; c < NUM_CL; c++)
          for (int j = 0; j < VPC; j++)
            if (int'(func_in) == vecval(c, j)) hc = c;
      m_hit = (hc >= 0) ? (1 << hc) : 0;
      if (hc >= 0 && m_cnt[hc] < CMAX) m_cnt[hc]++;
      m_ta = emit;
      if (emit) m_rom = vecval(m_sel, m_idx);
      m_func = func_in;
      case (m_state)
        0: if (lp && !m_lpd) begin m_sel = mi; m_idx = 0; m_state = 1; end
        1: begin
          if (!lp) m_state = 0;
          else begin
            if (m_idx == VPC - 1) begin
              m_cnt[m_sel] = (mx + 1 > CMAX) ? CMAX : mx + 1;
              m_state = 2;
            end else if (m_idx == WIN_I - 1) m_state = 2;
            m_idx++;
          end
        end
        default: if (!lp) m_state = 0;
      endcase
      m_lpd = lp;
    end
  end

  int w_act = 0;
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5", "cut_in", cut_i, m_ta ? m_rom : m_func);
      chk("R6", "test_active", ta_i, m_ta);
      chk("R4", "sel_cluster", sel_i, m_sel);
      chk("R2", "cluster_hit", hit_i, m_hit);
      if (ta_w) w_act++;
    end
  end

  task automatic step(input int v, input bit val, input bit lp);
    @(negedge clk);
    func_in  = VEC_W'(v);
    in_valid = val;
    lp_mode  = lp;
  endtask

  task automatic feed(input int v, input int times);
    for (int k = 0; k < times; k++) step(v, 1'b1, 1'b0);
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk("R1", "reset cut_in", cut_i, 0);
    chk("R1", "reset test_active", ta_i, 0);
    chk("R1", "reset sel_cluster", sel_i, 0);
    chk("R1", "reset cluster_hit", hit_i, 0);
    rst = 1'b0;
    // cluster counts: c0=3 c1=1 c2=2 c3=2
    feed(5, 1); feed(42, 1); feed(79, 1);
    feed(8, 1);
    feed(45, 1); feed(82, 1);
    feed(11, 1); feed(48, 1);
    feed(0, 1); feed(1, 1); feed(200, 1);           // R3 unmatched ignored
    for (int k = 0; k < 3; k++) step(153, 1'b0, 1'b0); // R3 invalid ignored
    step(0, 0, 0);
    // Window 1: full subset of cluster 1
    w_act = 0;
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R4", "window1 min select", sel_i, 1);
    chk("R7", "window1 limited instance select", sel_w, 1);
    step(0, 0, 1);
    chk("R6", "window1 first vector", cut_i, 153);
    chk("R6", "window1 test_active", ta_i, 1);
    for (int k = 0; k < 5; k++) step(0, 0, 1);
    chk("R7", "limited instance emitted count", w_act, WIN_W);
    step(0, 0, 0); step(0, 0, 0);
    // Window 2: c1 raised to 4, tie c2/c3 -> c2; abort after one vector
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R8", "window2 select after raise", sel_i, 2);
    chk("R7", "window2 limited instance keeps cluster", sel_w, 1);
    step(77, 0, 0);
    chk("R6", "window2 first vector", cut_i, 45);
    step(0, 0, 0);
    chk("R9", "abort test_active", ta_i, 0);
    chk("R9", "abort functional path", cut_i, 77);
    step(0, 0, 0);
    // Window 3: same cluster, restart at first vector
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R9", "window3 counter unchanged", sel_i, 2);
    step(0, 0, 1);
    chk("R9", "window3 restart vector", cut_i, 45);
    for (int k = 0; k < 5; k++) step(0, 0, 1);
    step(0, 0, 0); step(0, 0, 0);
    // Saturation: c1 4+66, c0 3+60, c2 5+58, c3 2+61 -> all 63
    feed(190, 66); feed(79, 60); feed(119, 58); feed(230, 61);
    step(0, 0, 0);
    step(0, 0, 1);
    step(0, 0, 1);
    chk("R3", "saturated tie select", sel_i, 0);
    step(0, 0, 1);
    chk("R3", "saturated window vector", cut_i, 5);
    for (int k = 0; k < 5; k++) step(0, 0, 1);
    step(0, 0, 0); step(0, 0, 0);
    finish_run();
  end

endmodule